// File: doc/BRIEF.md
# Smart-Card Convention UART Transceiver

This block is a half-duplex asynchronous serial transceiver for a card-style link. A character on the line is a low start bit, 8 data bits, one parity bit and one high stop bit. A single mode input picks one of two conventions. The direct convention sends true levels, least significant bit first, with even parity. The inverse convention sends inverted levels, most significant bit first, with odd parity on the logical data. The bit rate comes from a prescaler followed by an 8-bit divider. Each bit lasts 16 ticks of the divided clock.

Transmit data enters through a one-entry holding register using valid/ready. `tx_ready` is high exactly when the holding register is empty, and a character is taken on any cycle with `tx_valid && tx_ready`. While `tx_ready` is low, the producer must hold `tx_valid` and `tx_data`. Received characters leave through a one-entry buffer. `rx_valid` stays high until a cycle with `rx_ready` high, and that cycle consumes the character. The receive side does not exert back-pressure on the line. A character that arrives while the buffer is still full overwrites the buffer and is flagged as an overrun.

Parity errors are signalled on the wire in both directions. When the receiver finds bad parity, it pulls `txd` low for one bit time. When the transmitter finishes a character, it samples `rxd` to learn whether the far end reported an error.

Top module: `card_uart`

## Requirements
- R1: One bit lasts 16*(cfg_div+1)*P clock cycles. P is 1 for cfg_src_sel=0, 8 for cfg_src_sel=1 and 32 for cfg_src_sel=2 or 3. The line carries a low start bit, 9 character bits and a high stop bit, and idles high.
- R2: With cfg_inverse=0, character bit k (k=0..7) goes out as data[k] at its true level. The ninth bit is 1 when data has an odd count of ones (even parity).
- R3: With cfg_inverse=1, character bit k goes out as the inverse of data[7-k]. The ninth bit is the inverse of the odd-parity bit of data.
- R4: A character leaves the holding register only when tx_en=1. tx_ready is 1 exactly when the holding register is empty, so it returns to 1 as soon as a character moves into the shifter.
- R5: At the midpoint of the bit time that follows the stop bit, irq_tx pulses for one cycle and tx_nack takes the value 1 if rxd is low at that moment, 0 otherwise.
- R6: The receiver is armed only while rx_en=1. A low level that is high again at the midpoint of the start bit is discarded.
- R7: A received character is decoded with the convention of R2/R3 into rx_data. rx_valid is set and irq_rx pulses once.
- R8: A received parity mismatch sets err_parity. When nack_en=1, txd is also driven low for one bit time, starting half a bit after the stop-bit sample point.
- R9: A stop bit sampled low sets err_frame.
- R10: A character arriving while rx_valid=1 and rx_ready=0 overwrites rx_data and sets err_overrun, and it produces no irq_rx pulse.
- R11: err_sum is the OR of err_frame, err_parity and err_overrun.
- R12: rx_valid and the three receive error flags hold until a cycle with rx_ready=1, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_inverse | input | 1 | 0 = direct convention, 1 = inverse convention |
| cfg_src_sel | input | 2 | Prescaler select: 0 = /1, 1 = /8, 2 or 3 = /32 |
| cfg_div | input | 8 | Divider value n |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| nack_en | input | 1 | Enables the low error pulse on txd for bad received parity |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Transmit character |
| rx_valid | output | 1 | Receive buffer holds a character |
| rx_ready | input | 1 | Consume the buffered character |
| rx_data | output | 8 | Received character |
| err_frame | output | 1 | Stop bit was low |
| err_parity | output | 1 | Parity mismatch on the received character |
| err_overrun | output | 1 | Buffer was overwritten before it was read |
| err_sum | output | 1 | OR of the three receive error flags |
| tx_nack | output | 1 | Far end reported an error for the last sent character |
| irq_tx | output | 1 | One-cycle pulse on transmit completion |
| irq_rx | output | 1 | One-cycle pulse on a fresh received character |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
The bench uses the default parameters: 16 ticks per bit, an 8-bit divider and prescale ratios of 8 and 32. For most tests it sets the divider to 0 with the undivided source, so one bit is 16 clocks. At that rate every one of the 256 character values can be sent in the direct convention and received in the inverse convention. Smaller sets cover the other two direction/convention pairs. A few frames at the /8 and /32 settings, with nonzero divider values, check the bit-time arithmetic exactly. Faults are injected at the line: a flipped parity bit, a low stop bit, a short start glitch, and a far-end low pulse after a transmitted stop bit.

// File: rtl/card_uart_pkg.sv
package card_uart_pkg;
  localparam int CHAR_W  = 8;
  localparam int FRAME_W = CHAR_W + 1;

  typedef logic [CHAR_W-1:0]  char_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP, TX_GUARD} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT, RX_NACK} rx_state_e;

  // Line levels in send order; element 0 leaves first, the top element is parity.
  function automatic frame_t to_line(input char_t d, input logic inv);
    frame_t f;
    for (int i = 0; i < CHAR_W; i++) f[i] = (inv ? d[CHAR_W-1-i] : d[i]) ^ inv;
    f[CHAR_W] = ^d;
    return f;
  endfunction

  function automatic char_t from_line(input frame_t f, input logic inv);
    char_t d;
    for (int i = 0; i < CHAR_W; i++) begin
      if (inv) d[CHAR_W-1-i] = ~f[i];
      else     d[i]          = f[i];
    end
    return d;
  endfunction
endpackage

// File: rtl/card_uart_baud.sv
module card_uart_baud #(
  parameter int DIV_W    = 8,
  parameter int PRE_MID  = 8,
  parameter int PRE_SLOW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = $clog2(PRE_SLOW);

  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_en;

  always_comb begin
    case (src_sel)
      2'd0:    pre_lim = '0;
      2'd1:    pre_lim = PRE_W'(PRE_MID - 1);
      default: pre_lim = PRE_W'(PRE_SLOW - 1);
    endcase
  end

  assign pre_en = (pre_cnt >= pre_lim);
  assign tick   = pre_en && (div_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_en ? '0 : pre_cnt + 1'b1;
      if (pre_en) div_cnt <= (div_cnt == '0) ? div : div_cnt - 1'b1;
    end
  end

  // R1: with a prescaler active, ticks never come on consecutive cycles
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_sel != 2'd0) |=> (!tick || src_sel == 2'd0));
endmodule

// File: rtl/card_uart_tx.sv
module card_uart_tx
  import card_uart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        tx_en,
  input  logic        inv,
  input  logic        rxs,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  char_t       tx_data,
  output logic        line,
  output logic        irq_tx,
  output logic        far_nack
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);

  tx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx;
  frame_t           shreg;
  char_t            buf_q;
  logic             buf_full;
  logic             bit_end;

  assign bit_end  = tick && (cnt == CNT_LAST);
  assign tx_ready = !buf_full;

  always_comb begin
    case (state)
      TX_START: line = 1'b0;
      TX_DATA:  line = shreg[0];
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      buf_q    <= '0;
      buf_full <= 1'b0;
      irq_tx   <= 1'b0;
      far_nack <= 1'b0;
    end else begin
      irq_tx <= 1'b0;
      if (tx_valid && !buf_full) begin
        buf_q    <= tx_data;
        buf_full <= 1'b1;
      end
      if (state != TX_IDLE && tick) cnt <= cnt + 1'b1;
      case (state)
        TX_IDLE: if (tick && tx_en && buf_full) begin
          state    <= TX_START;
          cnt      <= '0;
          shreg    <= to_line(buf_q, inv);
          buf_full <= 1'b0;
        end
        TX_START: if (bit_end) begin
          state <= TX_DATA;
          idx   <= '0;
        end
        TX_DATA: if (bit_end) begin
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          idx   <= idx + 1'b1;
          if (idx == 4'(FRAME_W - 1)) state <= TX_STOP;
        end
        TX_STOP: if (bit_end) state <= TX_GUARD;
        TX_GUARD: begin
          if (tick && cnt == CNT_MID) begin
            irq_tx   <= 1'b1;
            far_nack <= !rxs;
          end
          if (bit_end) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R4: a frame only starts from a filled holding register with transmit enabled
  assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_START && $past(state) == TX_IDLE) |-> $past(tx_en && buf_full));
  // R4: an accepted character makes the register busy on the next cycle
  assert_accept_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/card_uart_rx.sv
module card_uart_rx
  import card_uart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  rx_en,
  input  logic  inv,
  input  logic  nack_en,
  input  logic  rxs,
  output logic  rx_valid,
  input  logic  rx_ready,
  output char_t rx_data,
  output logic  err_frame,
  output logic  err_parity,
  output logic  err_overrun,
  output logic  irq_rx,
  output logic  nack_drv
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx;
  frame_t           shreg;
  logic             bit_end, mid, deliver, perr, rd, busy_buf;

  assign bit_end  = tick && (cnt == CNT_LAST);
  assign mid      = tick && (cnt == CNT_MID);
  assign deliver  = rx_en && (state == RX_STOP) && mid;
  assign perr     = ^shreg;
  assign rd       = rx_valid && rx_ready;
  assign busy_buf = rx_valid && !rx_ready;
  assign nack_drv = (state == RX_NACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (!rx_en) begin
      state <= RX_IDLE;
      cnt   <= '0;
    end else begin
      if (state != RX_IDLE && tick) cnt <= cnt + 1'b1;
      case (state)
        RX_IDLE: if (!rxs) begin
          state <= RX_START;
          cnt   <= '0;
        end
        RX_START: begin
          if (mid && rxs)   state <= RX_IDLE;
          else if (bit_end) begin
            state <= RX_DATA;
            idx   <= '0;
          end
        end
        RX_DATA: begin
          if (mid) shreg <= {rxs, shreg[FRAME_W-1:1]};
          if (bit_end) begin
            idx <= idx + 1'b1;
            if (idx == 4'(FRAME_W - 1)) state <= RX_STOP;
          end
        end
        RX_STOP: if (mid) state <= (perr && nack_en) ? RX_WAIT : RX_IDLE;
        RX_WAIT: if (bit_end) state <= RX_NACK;
        RX_NACK: if (bit_end) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid    <= 1'b0;
      rx_data     <= '0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      irq_rx      <= 1'b0;
    end else begin
      irq_rx <= 1'b0;
      if (deliver) begin
        rx_data     <= from_line(shreg, inv);
        rx_valid    <= 1'b1;
        err_frame   <= !rxs;
        err_parity  <= perr;
        err_overrun <= busy_buf;
        irq_rx      <= !busy_buf;
      end else if (rd) begin
        rx_valid    <= 1'b0;
        err_frame   <= 1'b0;
        err_parity  <= 1'b0;
        err_overrun <= 1'b0;
      end
    end
  end

  // R12: an unread character stays valid
  assert_hold_until_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
  // R10: an overwrite never raises the receive interrupt
  assert_overrun_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> !irq_rx);
  // R6: dropping the enable returns the receiver to idle
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == RX_IDLE));
endmodule

// File: rtl/card_uart.sv
module card_uart
  import card_uart_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int OSR      = 16,
  parameter int PRE_MID  = 8,
  parameter int PRE_SLOW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_inverse,
  input  logic [1:0]       cfg_src_sel,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             nack_en,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun,
  output logic             err_sum,
  output logic             tx_nack,
  output logic             irq_tx,
  output logic             irq_rx,
  input  logic             rxd,
  output logic             txd
);
  logic tick, rxd_m, rxs, tx_line, nack_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxs   <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxs   <= rxd_m;
    end
  end

  card_uart_baud #(.DIV_W(DIV_W), .PRE_MID(PRE_MID), .PRE_SLOW(PRE_SLOW)) u_baud (
    .clk(clk), .rst_n(rst_n), .src_sel(cfg_src_sel), .div(cfg_div), .tick(tick));

  card_uart_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .inv(cfg_inverse),
    .rxs(rxs), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .line(tx_line), .irq_tx(irq_tx), .far_nack(tx_nack));

  card_uart_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .inv(cfg_inverse),
    .nack_en(nack_en), .rxs(rxs), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .irq_rx(irq_rx), .nack_drv(nack_drv));

  assign err_sum = err_frame | err_parity | err_overrun;
  assign txd     = tx_line & ~nack_drv;
endmodule

// File: tb/test_card_uart.sv
module test_card_uart;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cfg_inverse, tx_en, rx_en, nack_en, tx_valid, rx_ready, rxd;
  logic [1:0] cfg_src_sel;
  logic [7:0] cfg_div, tx_data;
  logic       tx_ready, rx_valid, err_frame, err_parity, err_overrun, err_sum;
  logic       tx_nack, irq_tx, irq_rx, txd;
  logic [7:0] rx_data;

  card_uart i_card_uart (
    .clk(clk), .rst_n(rst_n), .cfg_inverse(cfg_inverse), .cfg_src_sel(cfg_src_sel),
    .cfg_div(cfg_div), .tx_en(tx_en), .rx_en(rx_en), .nack_en(nack_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .err_sum(err_sum), .tx_nack(tx_nack), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .rxd(rxd), .txd(txd));

  int total = 0, bad = 0, cyc = 0, n_irq_tx = 0, n_irq_rx = 0, bt = 16;
  bit done = 0;

  always @(posedge clk) begin
    cyc++;
    if (irq_tx) n_irq_tx++;
    if (irq_rx) n_irq_rx++;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    finish_run();
  end

  // Expected line bits in send order, built from the R2/R3 wording.
  function automatic logic [8:0] exp_line(input logic [7:0] d, input bit inv);
    logic [8:0] e;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    for (int k = 0; k < 8; k++) e[k] = inv ? ~d[7-k] : d[k];
    if (!inv) e[8] = (ones % 2 == 1);
    else      e[8] = ~(ones % 2 == 0);
    return e;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input bit inv, input int sel, input int dv);
    int p;
    cfg_inverse = inv;
    cfg_src_sel = sel[1:0];
    cfg_div     = dv[7:0];
    p  = (sel == 0) ? 1 : (sel == 1) ? 8 : 32;
    bt = 16 * (dv + 1) * p;
  endtask

  task automatic tx_write(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_fall();
    while (txd !== 1'b0) @(negedge clk);
  endtask

  task automatic tx_observe(input logic [7:0] d, input bit inv, input bit far);
    logic [8:0] e;
    int c0;
    e  = exp_line(d, inv);
    c0 = n_irq_tx;
    wait_fall();
    wait_n(bt / 2);
    check_eq("R1 start bit low", txd, 0);
    for (int k = 0; k < 9; k++) begin
      wait_n(bt);
      check_eq(inv ? "R3 tx line bit" : "R2 tx line bit", txd, e[k]);
    end
    wait_n(bt);
    check_eq("R1 stop bit high", txd, 1);
    wait_n(bt / 2);
    rxd = far ? 1'b0 : 1'b1;
    wait_n(bt);
    rxd = 1'b1;
    check_eq("R5 irq_tx count", n_irq_tx - c0, 1);
    check_eq("R5 tx_nack", tx_nack, far);
  endtask

  task automatic rx_drive(input logic [7:0] d, input bit inv, input bit flip_par, input bit stop_lvl);
    logic [8:0] e;
    e = exp_line(d, inv);
    if (flip_par) e[8] = ~e[8];
    rxd = 1'b0;
    wait_n(bt);
    for (int k = 0; k < 9; k++) begin
      rxd = e[k];
      wait_n(bt);
    end
    rxd = stop_lvl;
    wait_n(bt);
    rxd = 1'b1;
  endtask

  // Called at the end of the stop bit.
  task automatic rx_expect(input logic [7:0] d, input bit par, input bit frm, input bit ovr,
                           input int irq_exp, input bit nack_exp);
    check_eq("R7 rx_valid", rx_valid, 1);
    check_eq(ovr ? "R10 rx_data overwritten" : "R7 rx_data", rx_data, d);
    check_eq("R8 err_parity", err_parity, par);
    check_eq("R9 err_frame", err_frame, frm);
    check_eq("R10 err_overrun", err_overrun, ovr);
    check_eq("R11 err_sum", err_sum, par | frm | ovr);
    check_eq(ovr ? "R10 irq_rx count" : "R7 irq_rx count", n_irq_rx, irq_exp);
    wait_n(bt / 2);
    check_eq("R8 txd error pulse", txd, nack_exp ? 0 : 1);
    wait_n(bt / 2 + 8);
  endtask

  task automatic rx_read();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check_eq("R12 rx_valid cleared", rx_valid, 0);
    check_eq("R12 flags cleared", err_sum, 0);
  endtask

  initial begin
    int t0, irq0;
    rst_n = 0; cfg_inverse = 0; cfg_src_sel = 0; cfg_div = 0; tx_en = 0; rx_en = 0;
    nack_en = 0; tx_valid = 0; tx_data = 0; rx_ready = 0; rxd = 1;
    wait_n(5);
    rst_n = 1;
    wait_n(2);
    check_eq("R1 idle txd high", txd, 1);
    check_eq("R4 tx_ready after reset", tx_ready, 1);
    check_eq("R12 rx_valid after reset", rx_valid, 0);
    check_eq("R11 err_sum after reset", err_sum, 0);

    // R1: start bit duration for several divider settings, with 0xFF direct
    tx_en = 1;
    for (int s = 0; s < 4; s++) begin
      int sel, dv;
      sel = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 1 : 2;
      dv  = (s == 2) ? 2 : 0;
      set_cfg(0, sel, dv);
      wait_n(4);
      tx_write(8'hFF);
      wait_fall();
      t0 = cyc;
      while (txd !== 1'b1) @(negedge clk);
      check_eq("R1 bit time", cyc - t0, bt);
      wait_n(11 * bt + 4);
    end

    // R2: every value, direct convention; some frames answered with a far-end error
    set_cfg(0, 0, 0);
    wait_n(4);
    for (int d = 0; d < 256; d++) begin
      tx_write(8'(d));
      tx_observe(8'(d), 0, (d % 37) == 5);
    end
    // R3: inverse convention on a spread of values
    set_cfg(1, 0, 0);
    for (int k = 0; k < 16; k++) begin
      tx_write(8'(k * 29 + 3));
      tx_observe(8'(k * 29 + 3), 1, k == 7);
    end

    // R4: disabled transmitter holds the character
    set_cfg(0, 0, 0);
    tx_en = 0;
    tx_write(8'h3C);
    t0 = 0;
    for (int i = 0; i < 3 * bt; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) t0++;
    end
    check_eq("R4 no send while disabled", t0, 0);
    check_eq("R4 tx_ready low while held", tx_ready, 0);
    tx_en = 1;
    tx_observe(8'h3C, 0, 0);
    tx_write(8'h11);
    wait_fall();
    check_eq("R4 tx_ready back once shifting", tx_ready, 1);
    wait_n(12 * bt + 4);

    // Receive side
    tx_en = 0; rx_en = 1; nack_en = 1;
    set_cfg(1, 0, 0);
    wait_n(4);
    for (int d = 0; d < 256; d++) begin
      irq0 = n_irq_rx;
      rx_drive(8'(d), 1, 0, 1);
      rx_expect(8'(d), 0, 0, 0, irq0 + 1, 0);
      rx_read();
    end
    set_cfg(0, 0, 0);
    for (int k = 0; k < 16; k++) begin
      irq0 = n_irq_rx;
      rx_drive(8'(k * 53 + 1), 0, 0, 1);
      rx_expect(8'(k * 53 + 1), 0, 0, 0, irq0 + 1, 0);
      rx_read();
    end

    // R8: parity error with and without the line pulse
    irq0 = n_irq_rx;
    rx_drive(8'h96, 0, 1, 1);
    rx_expect(8'h96, 1, 0, 0, irq0 + 1, 1);
    rx_read();
    nack_en = 0;
    set_cfg(1, 0, 0);
    irq0 = n_irq_rx;
    rx_drive(8'h2B, 1, 1, 1);
    rx_expect(8'h2B, 1, 0, 0, irq0 + 1, 0);
    rx_read();
    nack_en = 1;

    // R9: low stop bit
    set_cfg(0, 0, 0);
    irq0 = n_irq_rx;
    rx_drive(8'h47, 0, 0, 0);
    rx_expect(8'h47, 0, 1, 0, irq0 + 1, 0);
    rx_read();

    // R10: overrun
    irq0 = n_irq_rx;
    rx_drive(8'hA5, 0, 0, 1);
    rx_expect(8'hA5, 0, 0, 0, irq0 + 1, 0);
    rx_drive(8'h3C, 0, 0, 1);
    rx_expect(8'h3C, 0, 0, 1, irq0 + 1, 0);
    rx_read();

    // R6: short glitch is discarded
    irq0 = n_irq_rx;
    rxd = 0;
    wait_n(4);
    rxd = 1;
    wait_n(2 * bt);
    check_eq("R6 glitch no rx_valid", rx_valid, 0);
    check_eq("R6 glitch no irq_rx", n_irq_rx, irq0);
    // R6: receiver disabled ignores a full frame
    rx_en = 0;
    rx_drive(8'h5E, 0, 0, 1);
    wait_n(bt);
    check_eq("R6 disabled no rx_valid", rx_valid, 0);
    check_eq("R6 disabled no irq_rx", n_irq_rx, irq0);

    finish_run();
  end
endmodule